// File: doc/BRIEF.md
# NAND Flash Register Front End

This block sits between a processor register bus and a byte-wide NAND flash device. Software writes command bytes, address bytes, write-data bytes and read requests into a small tagged queue. A strobe sequencer drains that queue in order and drives the flash pins. It raises the command latch or the address latch for the matching entry and pulses the write strobe or the read strobe for a programmable number of clocks. Status bits and sticky event flags tell software when the queue is full, when it has drained, and when the flash reports ready.

Reads take two steps. Software first writes any value to the read-request register, which queues a read strobe behind any earlier entries. When the strobe completes, the captured byte is held in the read-data register and a sticky ready flag is set. Software reads the byte and clears the flag by writing 1 to it. A single interrupt output combines the event flags through a mask register.

Top module: `nfc_front`

## Requirements
- R1: The control register is at offset 0. Bits [3:0] hold the write-strobe delay W, bits [7:4] the read-strobe delay R, bit 8 the bus width select and bit 9 the page size select. Reading offset 0 returns these 10 bits and zeros above them.
- R2: Each queued command, address or write-data entry produces one write-strobe pulse (nd_we_n low) of exactly W+1 clocks, with nd_ce_n low and the byte on nd_dout. A command (offset 4) has nd_cle high and nd_ale low. An address (offset 5) has nd_ale high and nd_cle low. Write data (offset 6) has both latches low.
- R3: A queue write (offsets 4 to 7) made while the 4-entry queue is full is discarded and sets flag bit 1 (overflow) at offset 2.
- R4: A write of any value to offset 7 queues a read strobe (nd_re_n low) of exactly R+1 clocks. The byte on nd_din at the last clock edge of the low phase is returned when offset 7 is read, and flag bit 3 is set at that edge.
- R5: Queue entries reach the pins in the order they were written. Each entry is issued exactly once, and at most one strobe is low at a time.
- R6: The status register at offset 1 reads as follows: bit 0 = nd_rdy; bit 1 = queue full; bit 2 = a write-data entry is queued or in progress; bit 3 = a read request is queued or in progress; bit 4 = queue empty and no strobe in progress.
- R7: Writing 1 to a bit of offset 2 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: Offset 3 holds a 5-bit mask. The irq output is high exactly when some flag bit is 1 and its mask bit is 0.
- R9: Flag bit 0 is set when nd_rdy goes from low to high; it is not set by a high level already present at reset. Flag bit 2 is set when the queue becomes empty and idle. Flag bit 4 is set when the last write-data entry in flight completes.
- R10: After reset, nd_ce_n, nd_we_n and nd_re_n are high, nd_cle, nd_ale and nd_doe are low, and control, mask, flags and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Masked OR of the event flags |
| nd_ce_n | output | 1 | Flash chip enable, active low |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, active low |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_dout | output | 8 | Byte driven to the flash |
| nd_doe | output | 1 | Output enable for nd_dout |
| nd_din | input | 8 | Byte returned by the flash |
| nd_rdy | input | 1 | Flash ready/busy, high when ready |

## Verification
The assertions assume that nd_rdy and nd_din are already synchronous to clk and that the control register is changed only while status bit 4 shows the block idle. The stimulus drives every input half a cycle away from the active edge. It rewrites the control register only after polling for idle, and it keeps the queue from overflowing by polling the full bit, except in one directed burst that overflows the queue on purpose. Read data comes from a counter that changes every cycle, so a capture taken one cycle early or late returns the wrong byte.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [1:0] {
        K_CMD = 2'd0,
        K_ADR = 2'd1,
        K_DWR = 2'd2,
        K_DRD = 2'd3
    } nfc_kind_e;

    typedef struct packed {
        nfc_kind_e  kind;
        logic [7:0] val;
    } nfc_ent_t;

    localparam logic [2:0] A_CTL  = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_FLG  = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_CMD  = 3'd4;
    localparam logic [2:0] A_RDAT = 3'd7;
endpackage

// File: rtl/nfc_fifo.sv
module nfc_fifo
    import nfc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  nfc_ent_t din,
    input  logic     pop,
    output nfc_ent_t dout,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        nfc_ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [CW-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign dout  = st_q.mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop && !empty) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push && !full) - CW'(pop && !empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
    import nfc_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             avail,
    input  nfc_ent_t         ent,
    input  logic [DLY_W-1:0] wdly,
    input  logic [DLY_W-1:0] rdly,
    input  logic [7:0]       nd_din,
    output logic             pop,
    output logic             done,
    output nfc_kind_e        kind,
    output logic [7:0]       cap_byte,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dout,
    output logic             doe
);
    typedef struct packed {
        logic             active;
        nfc_kind_e        kind;
        logic [7:0]       val;
        logic [DLY_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    assign pop      = !st_q.active && avail;
    assign done     = st_q.active && (st_q.cnt == '0);
    assign kind     = st_q.kind;
    assign cap_byte = nd_din;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.active = 1'b1;
            st_d.kind   = ent.kind;
            st_d.val    = ent.val;
            st_d.cnt    = (ent.kind == K_DRD) ? rdly : wdly;
        end else if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce_n = !st_q.active;
    assign cle  = st_q.active && (st_q.kind == K_CMD);
    assign ale  = st_q.active && (st_q.kind == K_ADR);
    assign we_n = !(st_q.active && (st_q.kind != K_DRD));
    assign re_n = !(st_q.active && (st_q.kind == K_DRD));
    assign doe  = st_q.active && (st_q.kind != K_DRD);
    assign dout = st_q.val;
endmodule

// File: rtl/nfc_front.sv
module nfc_front
    import nfc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DLY_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        nd_ce_n,
    output logic        nd_cle,
    output logic        nd_ale,
    output logic        nd_we_n,
    output logic        nd_re_n,
    output logic [7:0]  nd_dout,
    output logic        nd_doe,
    input  logic [7:0]  nd_din,
    input  logic        nd_rdy
);
    localparam int CTL_W = 2 * DLY_W + 2;
    localparam int PCW   = $clog2(DEPTH + 2);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic [4:0]       mask;
        logic [4:0]       flg;
        logic [7:0]       rdat;
        logic             rdy_prev;
        logic             was_busy;
        logic [PCW-1:0]   wpend;
        logic [PCW-1:0]   rpend;
    } top_st_t;

    top_st_t   st_d, st_q;
    nfc_ent_t  push_ent, head_ent;
    nfc_kind_e seq_kind;
    logic      fifo_empty, fifo_full, seq_pop, seq_done;
    logic      q_wr, push_ok, wb_empty;
    logic [7:0] cap_byte;
    logic [4:0] stat_w, flg_set, flg_clr;

    assign push_ent.kind = nfc_kind_e'(reg_addr[1:0]);
    assign push_ent.val  = reg_wdata[7:0];
    assign q_wr          = reg_wr && (reg_addr >= A_CMD);
    assign push_ok       = q_wr && !fifo_full;

    nfc_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .din(push_ent),
        .pop(seq_pop), .dout(head_ent), .empty(fifo_empty), .full(fifo_full)
    );

    nfc_strobe #(.DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .avail(!fifo_empty), .ent(head_ent),
        .wdly(st_q.ctl[DLY_W-1:0]), .rdly(st_q.ctl[2*DLY_W-1:DLY_W]),
        .nd_din(nd_din), .pop(seq_pop), .done(seq_done), .kind(seq_kind),
        .cap_byte(cap_byte), .ce_n(nd_ce_n), .cle(nd_cle), .ale(nd_ale),
        .we_n(nd_we_n), .re_n(nd_re_n), .dout(nd_dout), .doe(nd_doe)
    );

    assign wb_empty = fifo_empty && nd_ce_n;
    assign stat_w   = {wb_empty, (st_q.rpend != '0), (st_q.wpend != '0), fifo_full, nd_rdy};

    always_comb begin
        logic done_w, done_r;
        st_d   = st_q;
        done_w = seq_done && (seq_kind == K_DWR);
        done_r = seq_done && (seq_kind == K_DRD);

        st_d.wpend = st_q.wpend + PCW'(push_ok && (push_ent.kind == K_DWR)) - PCW'(done_w);
        st_d.rpend = st_q.rpend + PCW'(push_ok && (push_ent.kind == K_DRD)) - PCW'(done_r);
        if (done_r) st_d.rdat = cap_byte;

        st_d.rdy_prev = nd_rdy;
        st_d.was_busy = !wb_empty;

        flg_set[0] = nd_rdy && !st_q.rdy_prev;
        flg_set[1] = q_wr && fifo_full;
        flg_set[2] = wb_empty && st_q.was_busy;
        flg_set[3] = done_r;
        flg_set[4] = done_w && (st_d.wpend == '0);
        flg_clr    = (reg_wr && reg_addr == A_FLG) ? reg_wdata[4:0] : 5'd0;
        st_d.flg   = (st_q.flg & ~flg_clr) | flg_set;

        if (reg_wr && reg_addr == A_CTL)  st_d.ctl  = reg_wdata[CTL_W-1:0];
        if (reg_wr && reg_addr == A_MASK) st_d.mask = reg_wdata[4:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.rdy_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = 16'(st_q.ctl);
            A_STAT:  reg_rdata = 16'(stat_w);
            A_FLG:   reg_rdata = 16'(st_q.flg);
            A_MASK:  reg_rdata = 16'(st_q.mask);
            A_RDAT:  reg_rdata = 16'(st_q.rdat);
            default: reg_rdata = '0;
        endcase
    end

    assign irq = |(st_q.flg & ~st_q.mask);
endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       cle,
    input logic       ale,
    input logic       ce_n,
    input logic       we_n,
    input logic       re_n,
    input logic [4:0] stat,
    input logic [4:0] flags
);
    // R2: at most one latch enable
    a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // R5: never both strobes low
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R2: a strobe is only low with the chip enabled
    a_r2_ce_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    // R3: queue write while full raises overflow
    a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[2] && stat[1]) |=> flags[1]);

    // R4: end of a read strobe leaves the ready flag set
    a_r4_ready_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> flags[3]);

    // R6: idle status means no pin activity
    a_r6_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        stat[4] |-> (we_n && re_n && ce_n));
endmodule

bind nfc_front nfc_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .cle(nd_cle), .ale(nd_ale), .ce_n(nd_ce_n), .we_n(nd_we_n), .re_n(nd_re_n),
    .stat(stat_w), .flags(st_q.flg)
);

// File: tb/nfc_front_bench.sv
module nfc_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_doe;
    logic [7:0]  nd_dout;
    logic [7:0]  nd_din = '0;
    logic        nd_rdy = 1'b1;

    int n_chk = 0, n_fail = 0;
    int cur_wd = 0, cur_rd = 0;
    int exp_kind[$], exp_val[$], rd_exp[$];
    bit finished = 0;

    always #4 clk = ~clk;

    nfc_front u_nfc_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n),
        .nd_re_n(nd_re_n), .nd_dout(nd_dout), .nd_doe(nd_doe),
        .nd_din(nd_din), .nd_rdy(nd_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int strobe_len(input int dly);
        return dly + 1;
    endfunction

    // pin monitor: strobe lengths, latch types, byte order, read capture
    int we_len = 0, re_len = 0, m_kind = 0, m_val = 0, m_din = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nd_we_n) begin
                if (we_len == 0) begin
                    m_kind = nd_cle ? 0 : (nd_ale ? 1 : 2);
                    m_val  = nd_dout;
                    chk(!nd_ce_n && nd_doe, "R2 ce/doe during write", {nd_ce_n, nd_doe}, 1);
                end
                we_len++;
            end else if (we_len != 0) begin
                chk(we_len == strobe_len(cur_wd), "R2 write strobe length", we_len, strobe_len(cur_wd));
                if (exp_kind.size() == 0) begin
                    chk(0, "R5 unexpected write strobe", m_kind, -1);
                end else begin
                    int ek, ev;
                    ek = exp_kind.pop_front();
                    ev = exp_val.pop_front();
                    chk(ek == m_kind && ev == m_val, "R5 write order/type",
                        m_kind * 256 + m_val, ek * 256 + ev);
                end
                we_len = 0;
            end
            if (!nd_re_n) begin
                re_len++;
            end else if (re_len != 0) begin
                chk(re_len == strobe_len(cur_rd), "R4 read strobe length", re_len, strobe_len(cur_rd));
                if (exp_kind.size() == 0) begin
                    chk(0, "R5 unexpected read strobe", 3, -1);
                end else begin
                    int ek, ev;
                    ek = exp_kind.pop_front();
                    ev = exp_val.pop_front();
                    chk(ek == 3, "R5 read order", 3, ek);
                end
                rd_exp.push_back(m_din);
                re_len = 0;
            end
        end
        nd_din = nd_din + 8'd37;
        if (!nd_re_n) m_din = nd_din;
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_ctl(input int wd, input int rdl, input int extra);
        wr(3'd0, 16'(wd | (rdl << 4) | (extra << 8)));
        cur_wd = wd; cur_rd = rdl;
    endtask

    task automatic qpush(input int kind, input int val);
        wr(3'(4 + kind), 16'(val));
        exp_kind.push_back(kind);
        exp_val.push_back(kind == 3 ? 0 : val);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        do begin
            @(negedge clk);
            rd(3'd1, v);
        end while (!v[4]);
    endtask

    task automatic wait_not_full();
        logic [15:0] v;
        rd(3'd1, v);
        while (v[1]) begin
            @(negedge clk);
            rd(3'd1, v);
        end
    endtask

    task automatic do_read();
        logic [15:0] v;
        int e;
        wait_not_full();
        qpush(3, 0);
        do begin
            @(negedge clk);
            rd(3'd2, v);
        end while (!v[3]);
        rd(3'd7, v);
        e = (rd_exp.size() != 0) ? rd_exp.pop_front() : -1;
        chk(v[7:0] == e[7:0] && v[15:8] == 0, "R4 read byte", v, e);
        wr(3'd2, 16'h0008);
        rd(3'd2, v);
        chk(v[3] == 1'b0, "R7 clear ready flag", v[3], 0);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(nd_ce_n && nd_we_n && nd_re_n && !nd_cle && !nd_ale && !nd_doe && !irq,
            "R10 idle pins", {nd_ce_n, nd_we_n, nd_re_n, nd_cle, nd_ale, nd_doe}, 6'b111000);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v); chk(v == 0, "R10 control reset", v, 0);
        rd(3'd2, v); chk(v == 0, "R10 flags reset", v, 0);
        rd(3'd1, v); chk(v == 16'h0011, "R6 status after reset", v, 16'h0011);

        // R1 control fields
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); chk(v == 16'h03FF, "R1 control readback", v, 16'h03FF);

        // R3 overflow burst with slow strobes
        set_ctl(15, 15, 0);
        for (int i = 0; i < 6; i++) begin
            wr(3'd4, 16'(8'hA0 + i));
            if (i < 5) begin exp_kind.push_back(0); exp_val.push_back(8'hA0 + i); end
        end
        rd(3'd1, v); chk(v[1] == 1'b1, "R6 full bit", v[1], 1);
        rd(3'd2, v); chk(v[1] == 1'b1, "R3 overflow flag", v[1], 1);
        wait_idle();
        chk(exp_kind.size() == 0, "R3 dropped entry not issued", exp_kind.size(), 0);
        @(negedge clk);
        rd(3'd2, v); chk(v[4:0] == 5'h06, "R9 drain flag with overflow", v, 5'h06);

        // R7 write-one-to-clear
        wr(3'd2, 16'h0002);
        rd(3'd2, v); chk(v[4:0] == 5'h04, "R7 clear only bit 1", v, 5'h04);

        // R8 interrupt masking
        chk(irq == 1'b1, "R8 irq unmasked", irq, 1);
        wr(3'd3, 16'h0004);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        wr(3'd2, 16'h001F);
        wr(3'd3, 16'h0000);
        rd(3'd2, v); chk(v == 0, "R7 clear all", v, 0);

        // R9 ready rise, R6 ready status
        nd_rdy = 1'b0;
        @(negedge clk);
        rd(3'd1, v); chk(v[0] == 1'b0, "R6 not-busy follows pin", v[0], 0);
        rd(3'd2, v); chk(v[0] == 1'b0, "R9 no flag on fall", v[0], 0);
        nd_rdy = 1'b1;
        @(negedge clk);
        rd(3'd2, v); chk(v[0] == 1'b1, "R9 flag on rise", v[0], 1);
        wr(3'd2, 16'h001F);

        // R2 types, R6 write pending, R9 page write done
        set_ctl(6, 3, 3);
        qpush(0, 8'h80); qpush(1, 8'h12); qpush(2, 8'h5A);
        rd(3'd1, v); chk(v[2] == 1'b1, "R6 write pending", v[2], 1);
        wait_idle();
        @(negedge clk);
        rd(3'd1, v); chk(v[2] == 1'b0, "R6 write pending cleared", v[2], 0);
        rd(3'd2, v); chk(v[4] == 1'b1, "R9 page write done", v[4], 1);
        wr(3'd2, 16'h001F);

        // R4 reads at several delays, including zero
        do_read();
        set_ctl(0, 0, 0);
        do_read();
        qpush(2, 8'h33);
        rd(3'd1, v); chk(v[3] == 1'b0, "R6 no read pending", v[3], 0);
        do_read();

        // constrained random mix
        for (int blk = 0; blk < 6; blk++) begin
            wait_idle();
            set_ctl($urandom % 6, $urandom % 6, $urandom % 4);
            for (int op = 0; op < 15; op++) begin
                int r;
                r = $urandom % 10;
                if (r >= 8) begin
                    do_read();
                end else begin
                    wait_not_full();
                    qpush((r < 3) ? 0 : ((r < 5) ? 1 : 2), $urandom % 256);
                end
            end
        end
        wait_idle();
        repeat (2) @(negedge clk);
        chk(exp_kind.size() == 0, "R5 all entries issued", exp_kind.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule